// File: doc/BRIEF.md
# Interleaved Multi-Bank Block-Read Memory

This block is a read-only memory built from many narrow banks. Consecutive memory words are spread across the banks by the low-order part of the word address, so a single access to every bank at once returns one wide word. A client asks for a block of data by giving a start byte address and a byte count. The block answers with as many wide words as the count needs, each with a per-byte valid mask and a flag on the final word.

Each wide access runs in two phases. An address decode of fixed length is followed by a fixed bank access time. At the end of decode, every bank latches its own in-bank row into an address buffer. At the end of the access time, every bank latches its output into a data buffer. Because the row is held in the address buffer, the decode of the next wide access can run while the banks are still busy, and its result enters the address buffers on the same edge that the data buffers fill. A parameter turns this overlap off, so that each decode waits until the previous access has finished.

Bank storage is a register array that is loaded at reset with a pattern derived from the address. No write path exists.

Top module: `ilv_mem`

## Requirements
- R1: While `arst_n` is low, `req_ready` and `rsp_valid` are 0. `req_ready` rises on the second clock edge after `arst_n` is released.
- R2: Byte address `a` holds `(37*(a mod 384) + 11) mod 256`. Memory word `w` is byte address `a` shifted right by one. It lives in bank `w mod 24` at row `(w/24) mod 8`. Lane `j` of the `k`-th response word (bits `16j+15:16j`) carries word `W0+24k+j`, where `W0` is the start word, with the lower byte address in the low byte.
- R3: With the consumer ready, the first response word is valid exactly 92 cycles after the accepting edge (12 decode cycles plus 80 access cycles).
- R4: With `OVERLAP=1` and the consumer ready, each further word arrives 80 cycles after the previous one, so the last word of a 64-byte read arrives 172 cycles after acceptance.
- R5: With `OVERLAP=0` and the consumer ready, each further word arrives 92 cycles after the previous one, so the last word of a 64-byte read arrives 184 cycles after acceptance.
- R6: A request of `n` bytes returns `max(1, ceil(n/48))` words. `rsp_last` is 1 on the final word only, and `rsp_valid` is 0 in the cycle after the final word is taken.
- R7: Mask bit `i` of word `k` is 1 exactly when `i < min(48, n-48k)`, so set bits form a contiguous run from bit 0. Data bytes whose mask bit is 0 read as zero.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the data, mask and last flag hold their values. The next capture waits for the consumer and comes at least one access time after the previous capture (80 cycles with overlap, 92 without).
- R9: `req_ready` is 0 from the accepting edge until the final word has been taken. A request offered while `req_ready` is 0 is not taken.
- R10: Address bit 0 is ignored. Addresses beyond byte 383 wrap around, so a block that crosses the end of the memory continues at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 16 | Start byte address |
| req_len | input | 16 | Byte count of the block |
| rsp_valid | output | 1 | Wide response word present |
| rsp_ready | input | 1 | Consumer takes the response word |
| rsp_data | output | 384 | Wide response word, 24 lanes of 16 bits |
| rsp_mask | output | 48 | Per-byte valid mask |
| rsp_last | output | 1 | Final word of the block |

## Verification
Two instances, one with overlap and one without, receive the same requests and each is compared every cycle against its own behavioural model. A 64-byte read from an aligned start with a consumer that never stalls separates the two modes by their 172- and 184-cycle completion times. Starts that fall in the middle of a bank row, at an odd address or near the top of memory test the rotation of lanes, the row increment for the lower banks and the wrap-around. Short, exact-multiple and zero-length counts test mask trimming and the last flag. A consumer that stalls for a long time or toggles its ready shows that held words stay stable and that later captures are pushed back rather than lost.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int unsigned PAT_MUL = 37;
  localparam int unsigned PAT_ADD = 11;

  // Reset contents of the storage: one byte per byte address.
  function automatic logic [7:0] pat_byte(input int unsigned byte_addr);
    int unsigned v;
    v = byte_addr * PAT_MUL + PAT_ADD;
    return v[7:0];
  endfunction

endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;

endmodule

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
  parameter int NBANKS  = 24,
  parameter int ROWS    = 8,
  parameter int WADDR_W = 15,
  parameter int BIDX_W  = 5,
  parameter int ROW_W   = 3
) (
  input  logic [WADDR_W-1:0] word,
  output logic [BIDX_W-1:0]  bank,
  output logic [ROW_W-1:0]   row
);

  logic [WADDR_W-1:0] quot;

  always_comb begin
    quot = word / WADDR_W'(NBANKS);
    bank = BIDX_W'(word % WADDR_W'(NBANKS));
    row  = ROW_W'(quot % WADDR_W'(ROWS));
  end

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int BANK_BYTES = 2,
  parameter int ROWS       = 8,
  parameter int ROW_W      = 3,
  parameter int NBANKS     = 24,
  parameter int BANK_ID    = 0,
  localparam int BANK_W    = 8 * BANK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abr_load,
  input  logic [ROW_W-1:0]  abr_in,
  input  logic              dbr_load,
  output logic [BANK_W-1:0] dbr_out
);

  logic [BANK_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0]  abr_q, abr_d;
  logic [BANK_W-1:0] dbr_q, dbr_d;

  // Storage: loaded once at reset, never written afterwards.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < ROWS; o++) begin
        for (int i = 0; i < BANK_BYTES; i++) begin
          mem_q[o][8*i +: 8] <= pat_byte(BANK_BYTES * (o * NBANKS + BANK_ID) + i);
        end
      end
    end
  end

  always_comb begin
    abr_d = abr_load ? abr_in : abr_q;
    dbr_d = dbr_load ? mem_q[abr_q] : dbr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abr_q <= '0;
      dbr_q <= '0;
    end else begin
      abr_q <= abr_d;
      dbr_q <= dbr_d;
    end
  end

  assign dbr_out = dbr_q;

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int NBANKS     = 24,
  parameter int BANK_BYTES = 2,
  parameter int ROWS       = 8,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int DECODE_CYC = 12,
  parameter int ACCESS_CYC = 80,
  parameter bit OVERLAP    = 1'b1
) (
  input  logic                             clk,
  input  logic                             arst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [LEN_W-1:0]                 req_len,
  output logic                             rsp_valid,
  input  logic                             rsp_ready,
  output logic [8*NBANKS*BANK_BYTES-1:0]   rsp_data,
  output logic [NBANKS*BANK_BYTES-1:0]     rsp_mask,
  output logic                             rsp_last
);

  localparam int BANK_W     = 8 * BANK_BYTES;
  localparam int WIDE_BYTES = NBANKS * BANK_BYTES;
  localparam int OFS_W      = $clog2(BANK_BYTES);
  localparam int WADDR_W    = ADDR_W - OFS_W;
  localparam int BIDX_W     = $clog2(NBANKS);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int DCNT_W     = $clog2(DECODE_CYC + 1);
  localparam int ACNT_W     = $clog2(ACCESS_CYC + 1);

  logic rst_s;

  ilv_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_s)
  );

  // Decode stage state
  logic               dec_busy_q, dec_busy_d;
  logic               dec_pend_q, dec_pend_d;
  logic [DCNT_W-1:0]  dec_cnt_q, dec_cnt_d;
  logic [WADDR_W-1:0] dec_word_q, dec_word_d;
  logic [LEN_W-1:0]   dec_rem_q, dec_rem_d;
  // Bank access stage state
  logic               acc_busy_q, acc_busy_d;
  logic [ACNT_W-1:0]  acc_cnt_q, acc_cnt_d;
  logic [BIDX_W-1:0]  acc_bank0_q, acc_bank0_d;
  logic [LEN_W-1:0]   acc_rem_q, acc_rem_d;
  // Response slot state
  logic                  out_valid_q, out_valid_d;
  logic [BIDX_W-1:0]     out_bank0_q, out_bank0_d;
  logic [WIDE_BYTES-1:0] out_mask_q, out_mask_d;
  logic                  out_last_q, out_last_d;

  logic accept, slot_free, cap, acc_free, abr_load, more, start_seq;
  logic [BIDX_W-1:0] split_bank;
  logic [ROW_W-1:0]  split_row, row_inc;
  logic [ROW_W-1:0]  bank_off [NBANKS];
  logic [BANK_W-1:0] dbr_all [NBANKS];
  logic [LEN_W-1:0]  take_n;
  logic [WIDE_BYTES-1:0] take_mask;

  ilv_addr_split #(
    .NBANKS  (NBANKS),
    .ROWS    (ROWS),
    .WADDR_W (WADDR_W),
    .BIDX_W  (BIDX_W),
    .ROW_W   (ROW_W)
  ) u_split (
    .word (dec_word_q),
    .bank (split_bank),
    .row  (split_row)
  );

  assign row_inc = (split_row == ROW_W'(ROWS - 1)) ? '0 : split_row + 1'b1;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    // Banks below the start bank hold the next row of this wide access.
    assign bank_off[b] = (BIDX_W'(b) < split_bank) ? row_inc : split_row;

    ilv_bank #(
      .BANK_BYTES (BANK_BYTES),
      .ROWS       (ROWS),
      .ROW_W      (ROW_W),
      .NBANKS     (NBANKS),
      .BANK_ID    (b)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_s),
      .abr_load (abr_load),
      .abr_in   (bank_off[b]),
      .dbr_load (cap),
      .dbr_out  (dbr_all[b])
    );
  end

  // Handshake and stage hand-over strobes
  always_comb begin
    req_ready = rst_s & ~dec_busy_q & ~dec_pend_q & ~acc_busy_q & ~out_valid_q;
    accept    = req_valid & req_ready;
    slot_free = ~out_valid_q | rsp_ready;
    cap       = acc_busy_q & (acc_cnt_q == '0) & slot_free;
    acc_free  = ~acc_busy_q | cap;
    abr_load  = dec_busy_q & (dec_cnt_q == '0) & acc_free;
    more      = dec_rem_q > LEN_W'(WIDE_BYTES);
    start_seq = ~OVERLAP & dec_pend_q & cap;
  end

  // Decode stage next state
  always_comb begin
    dec_busy_d = dec_busy_q;
    dec_pend_d = dec_pend_q;
    dec_cnt_d  = dec_cnt_q;
    dec_word_d = dec_word_q;
    dec_rem_d  = dec_rem_q;
    if (dec_busy_q && dec_cnt_q != '0) begin
      dec_cnt_d = dec_cnt_q - 1'b1;
    end
    if (accept) begin
      dec_busy_d = 1'b1;
      dec_cnt_d  = DCNT_W'(DECODE_CYC - 1);
      dec_word_d = req_addr[ADDR_W-1:OFS_W];
      dec_rem_d  = req_len;
    end else if (abr_load) begin
      dec_busy_d = 1'b0;
      if (more) begin
        dec_word_d = dec_word_q + WADDR_W'(NBANKS);
        dec_rem_d  = dec_rem_q - LEN_W'(WIDE_BYTES);
        if (OVERLAP) begin
          dec_busy_d = 1'b1;
          dec_cnt_d  = DCNT_W'(DECODE_CYC - 1);
        end else begin
          dec_pend_d = 1'b1;
        end
      end
    end else if (start_seq) begin
      dec_busy_d = 1'b1;
      dec_pend_d = 1'b0;
      dec_cnt_d  = DCNT_W'(DECODE_CYC - 1);
    end
  end

  // Access stage next state
  always_comb begin
    acc_busy_d  = acc_busy_q;
    acc_cnt_d   = acc_cnt_q;
    acc_bank0_d = acc_bank0_q;
    acc_rem_d   = acc_rem_q;
    if (abr_load) begin
      acc_busy_d  = 1'b1;
      acc_cnt_d   = ACNT_W'(ACCESS_CYC - 1);
      acc_bank0_d = split_bank;
      acc_rem_d   = dec_rem_q;
    end else if (cap) begin
      acc_busy_d = 1'b0;
    end else if (acc_busy_q && acc_cnt_q != '0) begin
      acc_cnt_d = acc_cnt_q - 1'b1;
    end
  end

  // Response slot next state
  always_comb begin
    take_n = (acc_rem_q > LEN_W'(WIDE_BYTES)) ? LEN_W'(WIDE_BYTES) : acc_rem_q;
    for (int i = 0; i < WIDE_BYTES; i++) begin
      take_mask[i] = LEN_W'(i) < take_n;
    end
    out_valid_d = out_valid_q;
    out_bank0_d = out_bank0_q;
    out_mask_d  = out_mask_q;
    out_last_d  = out_last_q;
    if (cap) begin
      out_valid_d = 1'b1;
      out_bank0_d = acc_bank0_q;
      out_mask_d  = take_mask;
      out_last_d  = acc_rem_q <= LEN_W'(WIDE_BYTES);
    end else if (rsp_ready) begin
      out_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dec_busy_q  <= 1'b0;
      dec_pend_q  <= 1'b0;
      dec_cnt_q   <= '0;
      dec_word_q  <= '0;
      dec_rem_q   <= '0;
      acc_busy_q  <= 1'b0;
      acc_cnt_q   <= '0;
      acc_bank0_q <= '0;
      acc_rem_q   <= '0;
      out_valid_q <= 1'b0;
      out_bank0_q <= '0;
      out_mask_q  <= '0;
      out_last_q  <= 1'b0;
    end else begin
      dec_busy_q  <= dec_busy_d;
      dec_pend_q  <= dec_pend_d;
      dec_cnt_q   <= dec_cnt_d;
      dec_word_q  <= dec_word_d;
      dec_rem_q   <= dec_rem_d;
      acc_busy_q  <= acc_busy_d;
      acc_cnt_q   <= acc_cnt_d;
      acc_bank0_q <= acc_bank0_d;
      acc_rem_q   <= acc_rem_d;
      out_valid_q <= out_valid_d;
      out_bank0_q <= out_bank0_d;
      out_mask_q  <= out_mask_d;
      out_last_q  <= out_last_d;
    end
  end

  // Lane rotation from the data buffers, then trimming of unrequested bytes
  always_comb begin
    for (int j = 0; j < NBANKS; j++) begin
      int src;
      src = int'(out_bank0_q) + j;
      if (src >= NBANKS) src = src - NBANKS;
      rsp_data[j*BANK_W +: BANK_W] = dbr_all[BIDX_W'(src)];
    end
    for (int i = 0; i < WIDE_BYTES; i++) begin
      if (!out_mask_q[i]) rsp_data[8*i +: 8] = 8'h00;
    end
  end

  assign rsp_valid = out_valid_q;
  assign rsp_mask  = out_mask_q;
  assign rsp_last  = out_last_q;

endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int DATA_W     = 384,
  parameter int MASK_W     = 48,
  parameter int DECODE_CYC = 12,
  parameter int ACCESS_CYC = 80
) (
  input logic              clk,
  input logic              arst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [MASK_W-1:0] rsp_mask,
  input logic              rsp_last
);

  int unsigned since_acc;
  logic        seen_rsp;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      since_acc <= 0;
      seen_rsp  <= 1'b0;
    end else if (req_valid && req_ready) begin
      since_acc <= 0;
      seen_rsp  <= 1'b0;
    end else begin
      if (since_acc < 32'hFFFF_0000) since_acc <= since_acc + 1;
      if (rsp_valid) seen_rsp <= 1'b1;
    end
  end

  // R3
  first_latency_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rsp_valid) && !seen_rsp |-> since_acc == DECODE_CYC + ACCESS_CYC);

  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);

  // R7
  mask_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_valid |-> (rsp_mask & (rsp_mask + MASK_W'(1))) == '0);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_mask) && $stable(rsp_last));

  // R9
  busy_while_out_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_valid |-> !req_ready);

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!arst_n)
    req_valid && req_ready |=> !req_ready);

endmodule

bind ilv_mem ilv_mem_chk #(
  .DATA_W     (8*NBANKS*BANK_BYTES),
  .MASK_W     (NBANKS*BANK_BYTES),
  .DECODE_CYC (DECODE_CYC),
  .ACCESS_CYC (ACCESS_CYC)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_mask  (rsp_mask),
  .rsp_last  (rsp_last)
);

// File: tb/tb_ilv_ref.sv
module tb_ilv_ref #(
  parameter bit OVERLAP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [15:0]  req_addr,
  input  logic [15:0]  req_len,
  input  logic         rsp_ready,
  output logic         exp_ready,
  output logic         exp_valid,
  output logic [383:0] exp_data,
  output logic [47:0]  exp_mask,
  output logic         exp_last
);

  int  next_cap, k, nacc, w0, len, rst_edges;
  bit  active;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active = 0; exp_valid = 0; exp_ready = 0; rst_edges = 0;
      exp_data = '0; exp_mask = '0; exp_last = 0; next_cap = 0; k = 0;
    end else begin
      bit take;
      take = req_valid && exp_ready;
      if (next_cap > 0) next_cap = next_cap - 1;
      if (active && next_cap == 0 && (!exp_valid || rsp_ready)) begin
        int rem, nb;
        rem = len - 48 * k;
        nb  = (rem > 48) ? 48 : rem;
        for (int j = 0; j < 24; j++) begin
          for (int i = 0; i < 2; i++) begin
            int a, b;
            a = ((w0 + 24 * k + j) * 2 + i) % 384;
            b = 2 * j + i;
            exp_mask[b] = (b < nb);
            exp_data[8*b +: 8] = (b < nb) ? 8'((a * 37 + 11) % 256) : 8'h00;
          end
        end
        exp_last  = (k == nacc - 1);
        exp_valid = 1;
        k = k + 1;
        if (k < nacc) next_cap = OVERLAP ? 80 : 92;
        else active = 0;
      end else if (exp_valid && rsp_ready) begin
        exp_valid = 0;
      end
      if (take) begin
        active = 1; k = 0; next_cap = 92;
        len  = int'(req_len);
        nacc = (len == 0) ? 1 : (len + 47) / 48;
        w0   = int'(req_addr) >> 1;
      end
      if (rst_edges < 2) rst_edges = rst_edges + 1;
      exp_ready = (rst_edges >= 2) && !active && !exp_valid;
    end
  end

endmodule

// File: tb/tb_ilv_mem.sv
module tb_ilv_mem;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [1:0] req_v = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic rsp_ready = 1'b1;
  int   ready_mode = 0;

  logic         rdy  [2];
  logic         val  [2];
  logic [383:0] dat  [2];
  logic [47:0]  msk  [2];
  logic         lst  [2];
  logic         e_rdy [2];
  logic         e_val [2];
  logic [383:0] e_dat [2];
  logic [47:0]  e_msk [2];
  logic         e_lst [2];

  int errors = 0;
  int checks = 0;
  bit cmp_en = 0;
  bit finished = 0;
  int ncnt = 0;
  int t0 [2];
  int lat_first [2];
  int lat_last [2];
  bit pv [2];
  bit pr [2];
  logic [383:0] pd [2];
  logic [47:0]  pm [2];

  always #5 clk = ~clk;

  ilv_mem #(.OVERLAP(1'b1)) dut (
    .clk(clk), .arst_n(arst_n), .req_valid(req_v[0]), .req_ready(rdy[0]),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(val[0]), .rsp_ready(rsp_ready),
    .rsp_data(dat[0]), .rsp_mask(msk[0]), .rsp_last(lst[0]));

  ilv_mem #(.OVERLAP(1'b0)) dut_seq (
    .clk(clk), .arst_n(arst_n), .req_valid(req_v[1]), .req_ready(rdy[1]),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(val[1]), .rsp_ready(rsp_ready),
    .rsp_data(dat[1]), .rsp_mask(msk[1]), .rsp_last(lst[1]));

  tb_ilv_ref #(.OVERLAP(1'b1)) ref_ovl (
    .clk(clk), .rst_n(arst_n), .req_valid(req_v[0]), .req_addr(req_addr), .req_len(req_len),
    .rsp_ready(rsp_ready), .exp_ready(e_rdy[0]), .exp_valid(e_val[0]), .exp_data(e_dat[0]),
    .exp_mask(e_msk[0]), .exp_last(e_lst[0]));

  tb_ilv_ref #(.OVERLAP(1'b0)) ref_seq (
    .clk(clk), .rst_n(arst_n), .req_valid(req_v[1]), .req_addr(req_addr), .req_len(req_len),
    .rsp_ready(rsp_ready), .exp_ready(e_rdy[1]), .exp_valid(e_val[1]), .exp_data(e_dat[1]),
    .exp_mask(e_msk[1]), .exp_last(e_lst[1]));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the behavioural models, sampled mid-cycle
  always @(negedge clk) begin
    ncnt++;
    for (int d = 0; d < 2; d++) begin
      if (cmp_en) begin
        check(rdy[d] === e_rdy[d], "R9", $sformatf("req_ready dut%0d", d), 384'(rdy[d]), 384'(e_rdy[d]));
        check(val[d] === e_val[d], "R3/R4/R5/R8", $sformatf("rsp_valid dut%0d", d), 384'(val[d]), 384'(e_val[d]));
        if (val[d] && e_val[d]) begin
          check(dat[d] === e_dat[d], "R2 R10", $sformatf("rsp_data dut%0d", d), dat[d], e_dat[d]);
          check(msk[d] === e_msk[d], "R7", $sformatf("rsp_mask dut%0d", d), 384'(msk[d]), 384'(e_msk[d]));
          check(lst[d] === e_lst[d], "R6", $sformatf("rsp_last dut%0d", d), 384'(lst[d]), 384'(e_lst[d]));
        end
        // R8: a held word keeps its contents
        if (pv[d] && !pr[d]) begin
          check(val[d] && dat[d] === pd[d] && msk[d] === pm[d], "R8",
                $sformatf("held word dut%0d", d), dat[d], pd[d]);
        end
        if (req_v[d] && rdy[d]) begin
          t0[d] = ncnt; lat_first[d] = -1; lat_last[d] = -1;
        end
        if (val[d] && lat_first[d] < 0) lat_first[d] = ncnt - t0[d] - 1;
        if (val[d] && lst[d] && lat_last[d] < 0) lat_last[d] = ncnt - t0[d] - 1;
      end
      pv[d] = val[d]; pr[d] = rsp_ready; pd[d] = dat[d]; pm[d] = msk[d];
    end
  end

  // Consumer ready pattern
  initial begin
    int pc;
    pc = 0;
    forever begin
      @(posedge clk); #2;
      pc++;
      case (ready_mode)
        0: rsp_ready = 1'b1;
        1: rsp_ready = (pc % 3) != 0;
        default: rsp_ready = 1'b0;
      endcase
    end
  end

  task automatic send(input int a, input int n);
    @(posedge clk); #2;
    req_addr = 16'(a); req_len = 16'(n); req_v = 2'b11;
    while (req_v != 2'b00) begin
      bit w0, w1;
      w0 = req_v[0] && rdy[0];
      w1 = req_v[1] && rdy[1];
      @(posedge clk); #2;
      if (w0) req_v[0] = 1'b0;
      if (w1) req_v[1] = 1'b0;
    end
  endtask

  task automatic wait_idle();
    while (!(rdy[0] && rdy[1])) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    for (int d = 0; d < 2; d++) begin
      check(rdy[d] === 1'b0, "R1", "req_ready in reset", 384'(rdy[d]), 384'(0));
      check(val[d] === 1'b0, "R1", "rsp_valid in reset", 384'(val[d]), 384'(0));
    end
    @(posedge clk); #2;
    arst_n = 1'b1;
    cmp_en = 1;
    repeat (4) @(posedge clk);
    #2;
    for (int d = 0; d < 2; d++)
      check(rdy[d] === 1'b1, "R1", "req_ready after reset", 384'(rdy[d]), 384'(1));

    // R3 R4 R5: 64-byte aligned read, consumer always ready
    ready_mode = 0;
    send(0, 64);
    wait_idle();
    check(lat_first[0] == 92, "R3", "first word latency overlap", 384'(lat_first[0]), 384'(92));
    check(lat_first[1] == 92, "R3", "first word latency sequential", 384'(lat_first[1]), 384'(92));
    check(lat_last[0] == 172, "R4", "64-byte completion overlap", 384'(lat_last[0]), 384'(172));
    check(lat_last[1] == 184, "R5", "64-byte completion sequential", 384'(lat_last[1]), 384'(184));

    // R2 R6: one full word from the middle of a row (rotation)
    send(30, 48);
    wait_idle();
    // R10 R7: odd start address, single byte
    send(257, 1);
    wait_idle();
    // R10: crossing the top of memory, three words
    send(370, 100);
    wait_idle();
    // R6 R7: zero-length request still returns one empty final word
    send(64, 0);
    wait_idle();

    // R8: long stall, then release
    ready_mode = 2;
    send(10, 150);
    repeat (300) @(posedge clk);
    ready_mode = 0;
    wait_idle();

    // R8 R9: toggling consumer, exact multiple of the wide word
    ready_mode = 1;
    send(96, 96);
    wait_idle();
    ready_mode = 0;
    send(382, 200);
    wait_idle();
    repeat (5) @(posedge clk);
    summary();
  end

endmodule